// File: doc/BRIEF.md
# Range-Gated Receive Sample Buffer

This block sits after the decimation stage of a pulsed receiver. Each decimated complex sample arrives with a one-cycle valid strobe. The block lets a sample through only while a range window is open. The window is defined once per inter-pulse period by a start delay (near range) and a stop delay (far range), both counted in clock cycles. Samples outside the window are dropped rather than zero-filled, so the time spent outside the window uses no buffer space and no read bandwidth. Each admitted sample is packed into one 32-bit word and held in a first-in first-out store. A packet-ready flag tells the downstream reader when at least one whole packet can be drained.

A period counter restarts on every pulse trigger. When no trigger arrives, it wraps by itself at the programmed period. The period, start and stop settings are copied into working copies only at a period boundary, so a window that is already running is never cut short or stretched. Any change on the run input, whether a start or a stop, flushes the whole block: the store, the pointers, the counter and the sticky flags. The first word of a new run is therefore always that run's first gated sample.

The sample input is valid-only and applies no back-pressure: a sample that finds the store full is lost and latches the overrun flag. The read side is valid/ready. `rd_valid` is high while a word is held, and `rd_data` shows the oldest word. That word is removed at a clock edge where both `rd_valid` and `rd_ready` are high. When `rd_ready` is held low, the word stays in place for as long as needed.

Top module: `rgate_rx_buffer`

## Requirements
- R1: A sample is stored only when `s_valid` is high, `run` has been high for more than one cycle, and the period count c satisfies start <= c < stop. Every other sample is discarded, and no word is written in its place.
- R2: The period count starts at 0, rises by one each cycle, and returns to 0 after reaching period-1. A high `pulse_trig` returns it to 0 at the next edge.
- R3: A stored word holds the in-phase value in bits 31:16 and the quadrature value in bits 15:0. Words leave the buffer in arrival order.
- R4: `pkt_ready` is high exactly when the buffer holds at least PKT_WORDS words.
- R5: `rd_valid` is high exactly when the buffer is not empty. A word is removed only at an edge where both `rd_valid` and `rd_ready` are high. Holding `rd_ready` high while the buffer is empty has no effect.
- R6: At the edge where `run` differs from its value one cycle earlier, the buffer is emptied, `overrun` and `cfg_err` are cleared, and the period count returns to 0. No sample is stored in that cycle.
- R7: If the working settings have stop <= start or stop > period, no sample is stored. While running with such settings, `cfg_err` rises at the next edge and stays high until the next flush.
- R8: A gated sample that meets a full buffer (NUM_PKTS*PKT_WORDS words) is discarded, and `overrun` is set. `overrun` is cleared only by a flush.
- R9: The period, start and stop inputs are captured only at a period boundary: a wrap, a trigger or a flush. Changes between boundaries do not affect the window in progress.
- R10: After reset the buffer is empty, and `rd_valid`, `pkt_ready`, `overrun` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start/stop level; each change flushes the block |
| pulse_trig | input | 1 | Pulse trigger; restarts the period count |
| cfg_period | input | CNT_W | Inter-pulse period in cycles |
| cfg_start | input | CNT_W | Window opening delay in cycles |
| cfg_stop | input | CNT_W | Window closing delay in cycles |
| s_valid | input | 1 | Decimated sample strobe |
| s_i | input | 16 | In-phase sample |
| s_q | input | 16 | Quadrature sample |
| rd_data | output | 32 | Oldest stored word |
| rd_valid | output | 1 | Buffer holds a word |
| rd_ready | input | 1 | Reader takes the word at this edge |
| pkt_ready | output | 1 | At least one full packet is stored |
| overrun | output | 1 | Sticky: a gated sample was lost to a full buffer |
| cfg_err | output | 1 | Sticky: the working settings cannot open a window |

## Verification
The bench runs several stimulus patterns, each aimed at a different failure:
- Dense strobes with no reader fill the buffer and separate a correct drop-and-flag on a full buffer from a silent overwrite.
- Sparse strobes and an intermittent reader catch ordering and handshake errors.
- Triggers that arrive before the period ends cut the window short, which exposes a counter that ignores the trigger.
- A settings change in the middle of a window separates capture at a boundary from immediate use.
- A stop and restart followed by a measured drain confirms that the first word of the new run is its first in-window sample and that exactly one window's worth of words was stored.
- Invalid window settings must yield the error flag and no data.

// File: rtl/rgb_pkg.sv
package rgb_pkg;
  localparam int unsigned IQ_W   = 16;
  localparam int unsigned WORD_W = 2 * IQ_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_iq(input logic [IQ_W-1:0] i_v,
                                    input logic [IQ_W-1:0] q_v);
    return {i_v, q_v};
  endfunction
endpackage

// File: rtl/rgb_run_ctrl.sv
module rgb_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic flush,
  output logic active
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  // any edge of run, start or stop, empties the whole block
  assign flush  = run ^ run_q;
  assign active = run & run_q;
endmodule

// File: rtl/rgb_gate_timer.sv
module rgb_gate_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             active,
  input  logic             trig,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_stop,
  output logic             gate,
  output logic             cfg_err
);
  logic [CNT_W-1:0] cnt, sh_per, sh_start, sh_stop;
  logic [CNT_W:0]   cnt_nxt;
  logic             wrap, boundary, cfg_ok;

  assign cnt_nxt  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap     = cnt_nxt >= {1'b0, sh_per};
  assign boundary = flush | trig | wrap;
  assign cfg_ok   = (sh_stop > sh_start) && (sh_stop <= sh_per);
  assign gate     = cfg_ok && (cnt >= sh_start) && (cnt < sh_stop);

  // working settings change only where a period begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh_per   <= '0;
      sh_start <= '0;
      sh_stop  <= '0;
    end else if (boundary) begin
      cnt      <= '0;
      sh_per   <= cfg_period;
      sh_start <= cfg_start;
      sh_stop  <= cfg_stop;
    end else begin
      cnt      <= cnt_nxt[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cfg_err <= 1'b0;
    else if (flush)             cfg_err <= 1'b0;
    else if (active && !cfg_ok) cfg_err <= 1'b1;
  end

  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < sh_per));

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(sh_per) && $stable(sh_start) && $stable(sh_stop)));

  p_cfgerr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !flush) |=> cfg_err);
endmodule

// File: rtl/rgb_fifo.sv
module rgb_fifo #(
  parameter int unsigned DEPTH     = 512,
  parameter int unsigned PKT_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  rgb_pkg::word_t wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output rgb_pkg::word_t rd_data,
  output logic          pkt_ready,
  output logic          overrun
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] PKT_C  = CW'(PKT_WORDS);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  rgb_pkg::word_t mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;
  logic [CW-1:0]  count;
  logic           full, push, pop;

  assign full      = (count == FULL_C);
  assign push      = wr_en & ~full;
  assign pop       = rd_ready & rd_valid;
  assign rd_valid  = (count != '0);
  assign rd_data   = mem[rptr];
  assign pkt_ready = (count >= PKT_C);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == LAST_C) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST_C) ? '0 : rptr + 1'b1;
      count <= count + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
      if (wr_en && full) overrun <= 1'b1;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_en && !flush) |=> !rd_valid);
endmodule

// File: rtl/rgate_rx_buffer.sv
module rgate_rx_buffer #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned PKT_WORDS = 256,
  parameter int unsigned NUM_PKTS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse_trig,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_stop,
  input  logic             s_valid,
  input  logic [15:0]      s_i,
  input  logic [15:0]      s_q,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             pkt_ready,
  output logic             overrun,
  output logic             cfg_err
);
  localparam int unsigned DEPTH = PKT_WORDS * NUM_PKTS;

  logic flush, active, gate, wr_en;

  rgb_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .run(run), .flush(flush), .active(active)
  );

  rgb_gate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .active(active),
    .trig(pulse_trig), .cfg_period(cfg_period), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .gate(gate), .cfg_err(cfg_err)
  );

  // the window masks the strobe itself; nothing is zero-filled
  assign wr_en = s_valid & active & gate;

  rgb_fifo #(.DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .wr_data(rgb_pkg::pack_iq(s_i, s_q)), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .pkt_ready(pkt_ready),
    .overrun(overrun)
  );

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_valid && !overrun && !cfg_err));

  p_idle_no_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !rd_valid) |=> !rd_valid);
endmodule

// File: tb/test_rgate_rx_buffer.sv
module test_rgate_rx_buffer;
  localparam int CNT_W = 12;
  localparam int PKT   = 8;
  localparam int NPKT  = 2;
  localparam int DEPTH = PKT * NPKT;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, pulse_trig = 1'b0;
  logic [CNT_W-1:0] cfg_period = '0, cfg_start = '0, cfg_stop = '0;
  logic s_valid = 1'b0, rd_ready = 1'b0;
  logic [15:0] s_i = '0, s_q = '0, seq = '0;
  logic [31:0] rd_data;
  logic rd_valid, pkt_ready, overrun, cfg_err;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rgate_rx_buffer #(.CNT_W(CNT_W), .PKT_WORDS(PKT), .NUM_PKTS(NPKT)) i_rgate_rx_buffer (
    .clk(clk), .rst_n(rst_n), .run(run), .pulse_trig(pulse_trig),
    .cfg_period(cfg_period), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .s_valid(s_valid), .s_i(s_i), .s_q(s_q), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .pkt_ready(pkt_ready),
    .overrun(overrun), .cfg_err(cfg_err)
  );

  // behavioural reference
  int m_cnt, m_per, m_start, m_stop;
  bit m_runq, m_ovr, m_cerr;
  logic [31:0] mq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_start = 0; m_stop = 0;
      m_runq = 0; m_ovr = 0; m_cerr = 0; mq.delete();
    end else begin
      bit fl, ok, gt;
      int pre;
      fl = (run != m_runq);
      ok = (m_stop > m_start) && (m_stop <= m_per);
      if (fl) begin
        mq.delete(); m_ovr = 0; m_cerr = 0;
      end else begin
        gt  = ok && (m_cnt >= m_start) && (m_cnt < m_stop);
        pre = mq.size();
        if (run && s_valid && gt) begin
          if (pre == DEPTH) m_ovr = 1;
          else mq.push_back({s_i, s_q});
        end
        if (rd_ready && pre > 0) void'(mq.pop_front());
        if (run && !ok) m_cerr = 1;
      end
      if (fl || pulse_trig || (m_cnt + 1 >= m_per)) begin
        m_cnt = 0; m_per = int'(cfg_period);
        m_start = int'(cfg_start); m_stop = int'(cfg_stop);
      end else begin
        m_cnt++;
      end
      m_runq = run;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(rd_valid == (mq.size() > 0), "R5 rd_valid", 32'(rd_valid), 32'(mq.size() > 0));
    if (mq.size() > 0)
      chk(rd_data === mq[0], "R1 R2 R3 R9 word order/content", rd_data, mq[0]);
    chk(pkt_ready == (mq.size() >= PKT), "R4 pkt_ready", 32'(pkt_ready), 32'(mq.size() >= PKT));
    chk(overrun == m_ovr, "R8 overrun", 32'(overrun), 32'(m_ovr));
    chk(cfg_err == m_cerr, "R7 cfg_err", 32'(cfg_err), 32'(m_cerr));
  endtask

  task automatic set_sample();
    seq = seq + 16'd1;
    s_i = seq;
    s_q = seq ^ 16'hA5A5;
  endtask

  task automatic drive(input int n, input int vk, input int rk, input int tk);
    for (int c = 0; c < n; c++) begin
      cyc();
      set_sample();
      s_valid    = (vk != 0) && (c % vk == 0);
      rd_ready   = (rk != 0) && (c % rk == 0);
      pulse_trig = (tk != 0) && (c % tk == tk - 1);
    end
  endtask

  task automatic set_cfg(input int p, input int a, input int b);
    cfg_period = CNT_W'(p); cfg_start = CNT_W'(a); cfg_stop = CNT_W'(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp_first;
    int pops;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R10 reset state
    chk(!rd_valid && !pkt_ready && !overrun && !cfg_err, "R10 reset state",
        {28'd0, rd_valid, pkt_ready, overrun, cfg_err}, 32'd0);

    // dense strobes, no reader: fill and overrun
    set_cfg(40, 10, 20);
    run = 1'b1;
    drive(200, 1, 0, 0);
    chk(overrun == 1'b1, "R8 overrun after filling", 32'(overrun), 32'd1);
    chk(pkt_ready == 1'b1, "R4 packet ready when full", 32'(pkt_ready), 32'd1);

    // reader drains, then sparse patterns
    drive(60, 1, 2, 0);
    drive(300, 3, 3, 0);
    // early triggers shorten the period (R2)
    drive(300, 1, 2, 17);
    // settings changed mid-window take effect at a boundary (R9)
    set_cfg(100, 0, 50);
    drive(120, 1, 1, 0);
    set_cfg(100, 90, 95);
    drive(250, 2, 1, 0);

    // stop: flush (R6)
    run = 1'b0;
    drive(5, 1, 1, 0);
    chk(!rd_valid && !overrun, "R6 flush on stop", {30'd0, rd_valid, overrun}, 32'd0);

    // restart aligned: first word is first in-window sample
    set_cfg(30, 0, 8);
    rd_ready = 1'b0;
    s_valid = 1'b1;
    run = 1'b1;
    exp_first = {seq + 16'd1, (seq + 16'd1) ^ 16'hA5A5};
    drive(20, 1, 0, 0);
    chk(rd_data == exp_first, "R6 R3 first word after restart", rd_data, exp_first);
    s_valid = 1'b0;
    rd_ready = 1'b1;
    pops = 0;
    for (int k = 0; k < 20; k++) begin
      if (rd_valid) pops++;
      cyc();
    end
    chk(pops == 8, "R1 words stored in one window", 32'(pops), 32'd8);
    chk(!rd_valid, "R5 empty read has no effect", 32'(rd_valid), 32'd0);

    // invalid window: stop equal to start
    run = 1'b0;
    drive(3, 0, 0, 0);
    set_cfg(30, 10, 10);
    run = 1'b1;
    drive(40, 1, 1, 0);
    chk(cfg_err == 1'b1 && !rd_valid, "R7 bad window flags error, stores nothing",
        {30'd0, cfg_err, rd_valid}, 32'd2);
    // stop beyond period
    set_cfg(30, 5, 40);
    drive(80, 1, 0, 0);
    chk(!rd_valid, "R7 stop beyond period stores nothing", 32'(rd_valid), 32'd0);
    run = 1'b0;
    drive(3, 0, 0, 0);
    chk(!cfg_err, "R6 flush clears cfg_err", 32'(cfg_err), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule